// File: doc/BRIEF.md
# Pin Multiplexer with Pad Control

This block connects on-chip peripheral functions to a row of IO pads. A small write-only register file holds one configuration word per pad and one selector word per input function. For each pad, the configuration word picks its output source: either the pad's own GPIO data and direction bits, or one of the peripheral function outputs. The same word also sets the drive mode (open-drain or push-pull), the pull-up and pull-down requests, and whether a driven pad may be read back.

Input functions are wired the opposite way round. Each input function has a selector that names at most one pad, so two pads can never contend for the same function input. Functions listed in a parameter mask own their pad's direction through a single enable wire per function. While such a function drives its pad, the pull resistors are released, so no extra pull wires are needed. Only the configuration state is registered. Every path from a function to a pad, and from a pad to a function, is combinational, with no register stage in between.

Top module: `pinmux_top`

## Requirements
- R1: Synchronous reset leaves every pad tri-stated (`pad_oe`=0), with both pulls off and `pad_od`=0. Every `fn_in` reads 0, whatever the values on `pad_in`, `fn_out` and `fn_oe`.
- R2: The pad word at address p (p < NUM_PADS) has this layout: bits [SEL_W-1:0] source select, bit SEL_W GPIO output enable, SEL_W+1 GPIO data, SEL_W+2 open-drain, SEL_W+3 pull-up, SEL_W+4 pull-down, SEL_W+5 loopback. With select 0, the pad takes its direction and data from the GPIO bits.
- R3: A select value k in 1..NUM_FUNCS routes `fn_out[k-1]` to the pad. One function may feed several pads at the same time.
- R4: A select value above NUM_FUNCS tri-states the pad and drives `pad_out` to 0.
- R5: With the open-drain bit set, `pad_od`=1 and `pad_out`=0. `pad_oe` equals the direction AND NOT the data, so a 1 releases the pad and a 0 pulls it low. With the bit clear, `pad_oe` follows the direction and `pad_out` carries the data.
- R6: When the selected function's bit in FN_DIR_OWNER is set, the pad direction follows `fn_oe` of that function and the GPIO enable bit is ignored. For any other function, the GPIO enable bit sets the direction.
- R7: `pad_pu` and `pad_pd` are never both 1. If both pulls are requested, only pull-down is asserted. While a direction-owning function drives its pad, both pulls are off.
- R8: The selector at address NUM_PADS+j drives `fn_in[j]`. A value v in 1..NUM_PADS selects `pad_in[v-1]`. A value of 0, or any value above NUM_PADS, makes the input read 0.
- R9: A pad whose `pad_oe` is 1 reads as 0 to every input function that selects it, unless its loopback bit is set.
- R10: Changes on `pad_in`, `fn_out` and `fn_oe` reach the outputs in the same cycle, with no clock edge in between.
- R11: A configuration write takes effect at the clock edge that samples it and not earlier. A write to an address at or above NUM_PADS+NUM_IN changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration word address |
| cfg_wdata | input | DATA_W | Configuration write data |
| fn_out | input | NUM_FUNCS | Output data from each peripheral function |
| fn_oe | input | NUM_FUNCS | Direction request from each function (used by owners only) |
| fn_in | output | NUM_IN | Data delivered to each input function |
| pad_in | input | NUM_PADS | Value sensed at each pad |
| pad_out | output | NUM_PADS | Data driven to each pad cell |
| pad_oe | output | NUM_PADS | Output enable of each pad cell |
| pad_od | output | NUM_PADS | Drive mode per pad: 1 open-drain, 0 push-pull |
| pad_pu | output | NUM_PADS | Pull-up enable per pad |
| pad_pd | output | NUM_PADS | Pull-down enable per pad |

## Verification
The bench sets open-drain mode with data 1 and checks that the pad releases. A design that copied the data onto the pad would fight an external pull-up. It writes both pull requests to one pad and checks that only pull-down comes on, then turns on a direction-owning function and checks that the pulls drop, which catches a design that leaves a pull fighting the function's drive. Select and selector values just past their legal ranges (5 and 7 for pads, 9 for inputs) must tri-state the pad or read 0. A design with an off-by-one in the range check would instead route a random source or an unknown value. Driven pads with loopback clear must read back 0, and a write to an unmapped address must leave every output as it was, which exposes feedback leakage and address aliasing.

// File: rtl/pinmux_pkg.sv
`timescale 1ns/1ps
package pinmux_pkg;
  // Per-pad mode bits, LSB first: gpio_oe, gpio_out, open_drain, pull_up, pull_dn, loopback
  typedef struct packed {
    logic loopback;
    logic pull_dn;
    logic pull_up;
    logic open_drain;
    logic gpio_out;
    logic gpio_oe;
  } pad_mode_t;

  localparam int MODE_W = $bits(pad_mode_t);
endpackage

// File: rtl/pinmux_cfg_regs.sv
`timescale 1ns/1ps
module pinmux_cfg_regs
  import pinmux_pkg::*;
#(
  parameter int NUM_PADS = 8,
  parameter int NUM_IN   = 4,
  parameter int SEL_W    = 3,
  parameter int ISEL_W   = 4,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 9
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  output logic [NUM_PADS*SEL_W-1:0]   pad_sel_flat,
  output logic [NUM_PADS*MODE_W-1:0]  pad_mode_flat,
  output logic [NUM_IN*ISEL_W-1:0]    in_sel_flat
);
  localparam int PAD_W = SEL_W + MODE_W;

  // One word per pad: {mode, select}
  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad_word
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(p);
    logic [PAD_W-1:0] word_q;

    always_ff @(posedge clk) begin
      if (rst)
        word_q <= '0;
      else if (we && (addr == MY_ADDR))
        word_q <= wdata[PAD_W-1:0];
    end

    assign pad_sel_flat[p*SEL_W +: SEL_W]    = word_q[SEL_W-1:0];
    assign pad_mode_flat[p*MODE_W +: MODE_W] = word_q[PAD_W-1:SEL_W];
  end

  // One selector per input function, placed after the pad words
  for (genvar j = 0; j < NUM_IN; j++) begin : g_in_word
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(NUM_PADS + j);
    logic [ISEL_W-1:0] sel_q;

    always_ff @(posedge clk) begin
      if (rst)
        sel_q <= '0;
      else if (we && (addr == MY_ADDR))
        sel_q <= wdata[ISEL_W-1:0];
    end

    assign in_sel_flat[j*ISEL_W +: ISEL_W] = sel_q;
  end
endmodule

// File: rtl/pinmux_pad_slice.sv
`timescale 1ns/1ps
module pinmux_pad_slice
  import pinmux_pkg::*;
#(
  parameter int                   NUM_FUNCS    = 4,
  parameter int                   SEL_W        = 3,
  parameter logic [NUM_FUNCS-1:0] FN_DIR_OWNER = '0
) (
  input  logic [SEL_W-1:0]     sel,
  input  pad_mode_t            mode,
  input  logic [NUM_FUNCS-1:0] fn_out,
  input  logic [NUM_FUNCS-1:0] fn_oe,
  input  logic                 pad_in,
  output logic                 pad_out,
  output logic                 pad_oe,
  output logic                 pad_od,
  output logic                 pad_pu,
  output logic                 pad_pd,
  output logic                 rx
);
  localparam int              FIDX_W  = (NUM_FUNCS > 1) ? $clog2(NUM_FUNCS) : 1;
  localparam logic [SEL_W-1:0] MAX_SEL = SEL_W'(NUM_FUNCS);

  logic              data;
  logic              dir;
  logic              owned;
  logic [FIDX_W-1:0] fidx;

  assign fidx = FIDX_W'(sel - 1'b1);

  // Source and direction selection
  always_comb begin
    data  = mode.gpio_out;
    dir   = mode.gpio_oe;
    owned = 1'b0;
    if (sel != '0) begin
      if (sel <= MAX_SEL) begin
        data = fn_out[fidx];
        if (FN_DIR_OWNER[fidx]) begin
          dir   = fn_oe[fidx];
          owned = 1'b1;
        end
      end else begin
        data = 1'b0;
        dir  = 1'b0;
      end
    end
  end

  // Drive-mode resolution
  logic oe_int;
  logic fn_driving;

  assign oe_int     = mode.open_drain ? (dir & ~data) : dir;
  assign pad_oe     = oe_int;
  assign pad_out    = mode.open_drain ? 1'b0 : data;
  assign pad_od     = mode.open_drain;

  // Pulls: pull-down wins; an owning function that drives releases both
  assign fn_driving = owned & dir;
  assign pad_pd     = mode.pull_dn & ~fn_driving;
  assign pad_pu     = mode.pull_up & ~mode.pull_dn & ~fn_driving;

  // Read-back gate: a driven pad is hidden unless loopback is set
  assign rx         = pad_in & (~oe_int | mode.loopback);
endmodule

// File: rtl/pinmux_in_select.sv
`timescale 1ns/1ps
module pinmux_in_select #(
  parameter int NUM_PADS = 8,
  parameter int ISEL_W   = 4
) (
  input  logic [ISEL_W-1:0]   sel,
  input  logic [NUM_PADS-1:0] pad_rx,
  output logic                fn_in
);
  localparam int               PIDX_W  = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1;
  localparam logic [ISEL_W-1:0] MAX_SEL = ISEL_W'(NUM_PADS);

  logic [PIDX_W-1:0] pidx;
  assign pidx = PIDX_W'(sel - 1'b1);

  // A single index per function: contention is impossible by construction
  always_comb begin
    fn_in = 1'b0;
    if ((sel != '0) && (sel <= MAX_SEL))
      fn_in = pad_rx[pidx];
  end
endmodule

// File: rtl/pinmux_top.sv
`timescale 1ns/1ps
module pinmux_top
  import pinmux_pkg::*;
#(
  parameter int                   NUM_PADS     = 8,
  parameter int                   NUM_FUNCS    = 4,
  parameter int                   NUM_IN       = 4,
  parameter logic [NUM_FUNCS-1:0] FN_DIR_OWNER = 4'b0010,
  parameter int                   SEL_W        = $clog2(NUM_FUNCS + 1),
  parameter int                   ISEL_W       = $clog2(NUM_PADS + 1),
  parameter int                   ADDR_W       = $clog2(NUM_PADS + NUM_IN),
  parameter int                   DATA_W       = ((SEL_W + MODE_W) > ISEL_W) ? (SEL_W + MODE_W) : ISEL_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [DATA_W-1:0]    cfg_wdata,
  input  logic [NUM_FUNCS-1:0] fn_out,
  input  logic [NUM_FUNCS-1:0] fn_oe,
  output logic [NUM_IN-1:0]    fn_in,
  input  logic [NUM_PADS-1:0]  pad_in,
  output logic [NUM_PADS-1:0]  pad_out,
  output logic [NUM_PADS-1:0]  pad_oe,
  output logic [NUM_PADS-1:0]  pad_od,
  output logic [NUM_PADS-1:0]  pad_pu,
  output logic [NUM_PADS-1:0]  pad_pd
);
  logic [NUM_PADS*SEL_W-1:0]  pad_sel_flat;
  logic [NUM_PADS*MODE_W-1:0] pad_mode_flat;
  logic [NUM_IN*ISEL_W-1:0]   in_sel_flat;
  logic [NUM_PADS-1:0]        pad_rx;
  logic [NUM_PADS-1:0]        pad_lb;

  pinmux_cfg_regs #(
    .NUM_PADS(NUM_PADS), .NUM_IN(NUM_IN), .SEL_W(SEL_W),
    .ISEL_W(ISEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk           (clk),
    .rst           (rst),
    .we            (cfg_we),
    .addr          (cfg_addr),
    .wdata         (cfg_wdata),
    .pad_sel_flat  (pad_sel_flat),
    .pad_mode_flat (pad_mode_flat),
    .in_sel_flat   (in_sel_flat)
  );

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    pad_mode_t mode;
    assign mode      = pad_mode_t'(pad_mode_flat[p*MODE_W +: MODE_W]);
    assign pad_lb[p] = mode.loopback;

    pinmux_pad_slice #(
      .NUM_FUNCS(NUM_FUNCS), .SEL_W(SEL_W), .FN_DIR_OWNER(FN_DIR_OWNER)
    ) u_slice (
      .sel     (pad_sel_flat[p*SEL_W +: SEL_W]),
      .mode    (mode),
      .fn_out  (fn_out),
      .fn_oe   (fn_oe),
      .pad_in  (pad_in[p]),
      .pad_out (pad_out[p]),
      .pad_oe  (pad_oe[p]),
      .pad_od  (pad_od[p]),
      .pad_pu  (pad_pu[p]),
      .pad_pd  (pad_pd[p]),
      .rx      (pad_rx[p])
    );
  end

  for (genvar j = 0; j < NUM_IN; j++) begin : g_in
    pinmux_in_select #(
      .NUM_PADS(NUM_PADS), .ISEL_W(ISEL_W)
    ) u_isel (
      .sel    (in_sel_flat[j*ISEL_W +: ISEL_W]),
      .pad_rx (pad_rx),
      .fn_in  (fn_in[j])
    );
  end
endmodule

// File: rtl/pinmux_sva.sv
`timescale 1ns/1ps
module pinmux_sva #(
  parameter int NUM_PADS  = 8,
  parameter int NUM_FUNCS = 4,
  parameter int NUM_IN    = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic [NUM_PADS-1:0]         pad_out,
  input logic [NUM_PADS-1:0]         pad_oe,
  input logic [NUM_PADS-1:0]         pad_od,
  input logic [NUM_PADS-1:0]         pad_pu,
  input logic [NUM_PADS-1:0]         pad_pd,
  input logic [NUM_IN-1:0]           fn_in,
  input logic [NUM_PADS*$clog2(NUM_FUNCS+1)-1:0] pad_sel_flat,
  input logic [NUM_IN*$clog2(NUM_PADS+1)-1:0]    in_sel_flat,
  input logic [NUM_PADS-1:0]         pad_lb
);
  localparam int SEL_W  = $clog2(NUM_FUNCS + 1);
  localparam int ISEL_W = $clog2(NUM_PADS + 1);
  localparam int PIDX_W = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1;

  AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    (pad_pu & pad_pd) == '0); // R7

  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (rst)
    (pad_od & pad_out) == '0); // R5

  AST_RESET_SAFE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pad_oe == '0 && pad_pu == '0 && pad_pd == '0 && fn_in == '0)); // R1

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad_chk
    logic [SEL_W-1:0] s;
    assign s = pad_sel_flat[p*SEL_W +: SEL_W];
    AST_BAD_SEL_TRISTATE: assert property (@(posedge clk) disable iff (rst)
      (s > SEL_W'(NUM_FUNCS)) |-> (!pad_oe[p] && !pad_out[p])); // R4
  end

  for (genvar j = 0; j < NUM_IN; j++) begin : g_in_chk
    logic [ISEL_W-1:0] s;
    logic              valid;
    logic [PIDX_W-1:0] idx;
    assign s     = in_sel_flat[j*ISEL_W +: ISEL_W];
    assign valid = (s != '0) && (s <= ISEL_W'(NUM_PADS));
    assign idx   = PIDX_W'(s - 1'b1);

    AST_UNSELECTED_ZERO: assert property (@(posedge clk) disable iff (rst)
      !valid |-> !fn_in[j]); // R8

    AST_NO_FEEDBACK: assert property (@(posedge clk) disable iff (rst)
      (valid && pad_oe[idx] && !pad_lb[idx]) |-> !fn_in[j]); // R9
  end
endmodule

bind pinmux_top pinmux_sva #(
  .NUM_PADS(NUM_PADS), .NUM_FUNCS(NUM_FUNCS), .NUM_IN(NUM_IN)
) u_sva (
  .clk          (clk),
  .rst          (rst),
  .pad_out      (pad_out),
  .pad_oe       (pad_oe),
  .pad_od       (pad_od),
  .pad_pu       (pad_pu),
  .pad_pd       (pad_pd),
  .fn_in        (fn_in),
  .pad_sel_flat (pad_sel_flat),
  .in_sel_flat  (in_sel_flat),
  .pad_lb       (pad_lb)
);

// File: tb/pinmux_top_tb.sv
`timescale 1ns/1ps
module pinmux_top_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       cfg_we;
  logic [3:0] cfg_addr;
  logic [8:0] cfg_wdata;
  logic [3:0] fn_out, fn_oe, fn_in;
  logic [7:0] pad_in, pad_out, pad_oe, pad_od, pad_pu, pad_pd;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pinmux_top u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .fn_out(fn_out), .fn_oe(fn_oe), .fn_in(fn_in), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od), .pad_pu(pad_pu), .pad_pd(pad_pd)
  );

  // Pad word: {lb, pd, pu, od, out, oe, sel[2:0]}
  function automatic logic [8:0] mk(input int sel, input bit oe, input bit dout,
                                    input bit od, input bit pu, input bit pd, input bit lb);
    return {lb, pd, pu, od, dout, oe, 3'(sel)};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic apply_reset();
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    fn_out = '0; fn_oe = '0; pad_in = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [8:0] d);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
    @(posedge clk);
    #1 cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    fn_out = '1; fn_oe = '1; pad_in = '1;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk); #1;
    check("R1 pad_oe after reset", pad_oe, 0);
    check("R1 pulls after reset", {pad_pu, pad_pd}, 0);
    check("R1 pad_od after reset", pad_od, 0);
    check("R1 fn_in after reset", fn_in, 0);
  endtask

  task automatic t_gpio();
    apply_reset();
    wr(0, mk(0, 1, 1, 0, 0, 0, 0));
    wr(1, mk(0, 1, 0, 0, 0, 0, 0));
    wr(2, mk(0, 0, 1, 0, 0, 0, 0));
    #1;
    check("R2 gpio oe", pad_oe[2:0], 3'b011);
    check("R2 gpio data", pad_out[2:0], 3'b101);
    check("R2 push-pull mode", pad_od[2:0], 3'b000);
  endtask

  task automatic t_route();
    apply_reset();
    wr(3, mk(1, 1, 0, 0, 0, 0, 0));
    wr(4, mk(1, 1, 0, 0, 0, 0, 0));
    wr(5, mk(3, 1, 0, 0, 0, 0, 0));
    fn_out = 4'b0101; #1;
    check("R3 one-to-many route", pad_out[5:3], 3'b111);
    check("R3 routed oe", pad_oe[5:3], 3'b111);
    fn_out = 4'b0100; #1;
    check("R10 R3 same-cycle function change", pad_out[5:3], 3'b100);
    fn_out = 4'b0001; #1;
    check("R10 R3 second change", pad_out[5:3], 3'b011);
  endtask

  task automatic t_oor();
    apply_reset();
    fn_out = '1;
    wr(6, mk(5, 1, 1, 0, 0, 0, 0)); #1;
    check("R4 select 5 tri-state", {pad_oe[6], pad_out[6]}, 2'b00);
    wr(6, mk(7, 1, 1, 0, 0, 0, 0)); #1;
    check("R4 select 7 tri-state", {pad_oe[6], pad_out[6]}, 2'b00);
    wr(6, mk(4, 1, 0, 0, 0, 0, 0)); #1;
    check("R3 highest legal select", {pad_oe[6], pad_out[6]}, 2'b11);
  endtask

  task automatic t_od();
    apply_reset();
    wr(0, mk(0, 1, 1, 1, 0, 0, 0)); #1;
    check("R5 od data1 releases", {pad_od[0], pad_oe[0], pad_out[0]}, 3'b100);
    wr(0, mk(0, 1, 0, 1, 0, 0, 0)); #1;
    check("R5 od data0 pulls low", {pad_od[0], pad_oe[0], pad_out[0]}, 3'b110);
    wr(0, mk(0, 0, 0, 1, 0, 0, 0)); #1;
    check("R5 od input", pad_oe[0], 0);
    wr(1, mk(1, 1, 0, 1, 0, 0, 0));
    fn_out = 4'b0000; #1;
    check("R5 od function low", {pad_oe[1], pad_out[1]}, 2'b10);
    fn_out = 4'b0001; #1;
    check("R5 R10 od function high", {pad_oe[1], pad_out[1]}, 2'b00);
  endtask

  task automatic t_owner();
    apply_reset();
    wr(1, mk(2, 0, 0, 0, 0, 0, 0));
    fn_out = 4'b0010; fn_oe = 4'b0010; #1;
    check("R6 owner drives oe", {pad_oe[1], pad_out[1]}, 2'b11);
    fn_oe = 4'b0000; #1;
    check("R6 owner releases oe", pad_oe[1], 0);
    wr(1, mk(2, 1, 0, 0, 0, 0, 0)); #1;
    check("R6 gpio oe ignored for owner", pad_oe[1], 0);
    wr(2, mk(1, 1, 0, 0, 0, 0, 0)); #1;
    check("R6 non-owner uses gpio oe", pad_oe[2], 1);
  endtask

  task automatic t_pull();
    apply_reset();
    wr(7, mk(0, 0, 0, 0, 1, 0, 0)); #1;
    check("R7 pull-up alone", {pad_pu[7], pad_pd[7]}, 2'b10);
    wr(7, mk(0, 0, 0, 0, 1, 1, 0)); #1;
    check("R7 both requested -> pull-down", {pad_pu[7], pad_pd[7]}, 2'b01);
    wr(1, mk(2, 0, 0, 0, 1, 0, 0));
    fn_oe = 4'b0010; #1;
    check("R7 owner driving drops pull-up", {pad_pu[1], pad_pd[1]}, 2'b00);
    fn_oe = 4'b0000; #1;
    check("R7 owner idle keeps pull-up", {pad_pu[1], pad_pd[1]}, 2'b10);
    wr(1, mk(2, 0, 0, 0, 0, 1, 0));
    fn_oe = 4'b0010; #1;
    check("R7 owner driving drops pull-down", pad_pd[1], 0);
  endtask

  task automatic t_insel();
    apply_reset();
    wr(8, 9'd3);
    pad_in = 8'h04; #1;
    check("R8 selector picks pad2", fn_in, 4'b0001);
    pad_in = 8'h00; #1;
    check("R8 R10 follows pad same cycle", fn_in, 4'b0000);
    wr(9, 9'd0); wr(10, 9'd9); wr(11, 9'd8);
    pad_in = 8'hFF; #1;
    check("R8 zero and out-of-range read 0, pad7 reachable", fn_in, 4'b1001);
    pad_in = 8'h7F; #1;
    check("R8 pad7 low", fn_in, 4'b0001);
    wr(9, 9'd3); pad_in = 8'h04; #1;
    check("R8 two functions share one pad", fn_in, 4'b0011);
  endtask

  task automatic t_feedback();
    apply_reset();
    wr(8, 9'd3);
    wr(2, mk(0, 1, 1, 0, 0, 0, 0));
    pad_in = 8'h04; #1;
    check("R9 driven pad hidden", fn_in[0], 0);
    wr(2, mk(0, 1, 1, 0, 0, 0, 1)); #1;
    check("R9 loopback reads pad", fn_in[0], 1);
    wr(2, mk(0, 1, 1, 1, 0, 0, 0)); #1;
    check("R9 released od pad readable", fn_in[0], 1);
    wr(2, mk(0, 0, 0, 0, 0, 0, 0)); #1;
    check("R9 input pad readable", fn_in[0], 1);
  endtask

  task automatic t_write();
    logic [47:0] snap;
    apply_reset();
    pad_in = 8'hFF; fn_out = 4'b1111;
    cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = mk(0, 1, 1, 0, 0, 0, 0); #1;
    check("R11 no effect before edge", pad_oe[0], 0);
    @(posedge clk); #1 cfg_we = 1'b0;
    @(negedge clk); #1;
    check("R11 effect after edge", pad_oe[0], 1);
    wr(8, 9'd2);
    snap = {pad_out, pad_oe, pad_od, pad_pu, pad_pd, 4'b0, fn_in};
    wr(12, 9'h05A); wr(15, 9'h05A); #1;
    check("R11 unmapped writes ignored",
          {pad_out, pad_oe, pad_od, pad_pu, pad_pd, 4'b0, fn_in}, snap);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_gpio();
    t_route();
    t_oor();
    t_od();
    t_owner();
    t_pull();
    t_insel();
    t_feedback();
    t_write();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule